// File: doc/BRIEF.md
# Latched Alarm Status and Interrupt Register

This block gathers the live alarm conditions and the per-frame boundary pulses of a T3/E3 framer into one 16-bit status register. Software reads the register over a simple synchronous register bus. Alarm conditions arrive as levels: loss of signal, loss of frame, AIS, remote alarm and idle. The block samples them through one register stage and latches them in sticky bits. A read clears a sticky bit only when its condition has gone away. A condition that is still present therefore stays visible across any number of reads.

Each alarm bit also keeps a pending interrupt request. Any change of state of the condition sets it, whether the condition rises or falls. The two frame-boundary bits, one for transmit and one for receive, are plain pulse latches. A read clears them unconditionally. A pending request drives the interrupt output only when its per-bit mask bit is set and the master enable is also set. A separate register holds the per-bit masks. In E3 mode the idle bit is meaningless, so it is held at zero and can raise no interrupt.

Top module: `alarm_stat_irq`

## Requirements
- R1: The status register is read at address 0x12. Its bit positions are LOS=0, LOF=1, AIS=2, RAI=3, IDLE=4, TXSOF=5, RXSOF=6. Bits 15..7 read as 0. Read data appears on `rdData` one clock after the cycle in which `rdEn` is sampled, and it shows the register contents from before that read.
- R2: An alarm bit is set to 1 two clocks after its condition input goes high. A status read clears the bit only if the condition is low at the time of the read; otherwise the bit stays 1.
- R3: A change of state of an alarm condition, rising or falling, sets that bit's pending interrupt request.
- R4: `irq` is an active-high level. It is high only when `masterEn` is 1 and at least one pending request has its mask bit set to 1.
- R5: A status read releases all pending interrupt requests that have no new event in the same cycle.
- R6: TXSOF and RXSOF are set by a one-cycle pulse on `txSof` or `rxSof` at the next clock edge. A read clears them unconditionally. Each one also raises a pending request.
- R7: While `e3Mode` is 1, the IDLE bit and its pending request are held at 0.
- R8: If a set event and a status read fall in the same cycle, the event wins. The bit and its request stay 1 after the read.
- R9: The mask register is read and written at address 0x13 through data bits 6..0, using the same bit positions as the status register. Writes to 0x12 are ignored. Reads of any other address return 0.
- R10: After reset, every status bit, pending request, mask bit, `rdData` and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| almCond | input | 5 | Alarm condition levels (LOS, LOF, AIS, RAI, IDLE at bits 0..4) |
| txSof | input | 1 | Transmit frame boundary pulse |
| rxSof | input | 1 | Receive frame boundary pulse |
| e3Mode | input | 1 | 1 selects E3 mode, which suppresses the idle bit |
| masterEn | input | 1 | Master interrupt enable for this register |
| irq | output | 1 | Interrupt request level |

## Verification
Read data is due one clock after the read strobe. The scoreboard queues the expected word when the strobe is driven and compares it at the falling edge after the capturing rising edge.

An alarm input reaches its status bit and its pending request two clocks after it changes. A frame pulse reaches its bit after one clock. The bench therefore waits three falling edges after every condition change before it reads.

`irq` is combinational from the pending requests, the mask and the enable. It is sampled at the falling edge after the edge that set or released a request, or one falling edge after `masterEn` is changed.

// File: rtl/alarm_stat_pkg.sv
package alarm_stat_pkg;
  localparam int ALARM_N = 5;
  localparam int EVENT_N = 2;
  localparam int STAT_W  = ALARM_N + EVENT_N;
  localparam int IDLE_BIT = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   statRead;
    logic   maskWrite;
    logic   rdStrobe;
    rdSel_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/alarm_bit_cell.sv
module alarm_bit_cell (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic chgIn,
  input  logic clrRd,
  input  logic forceOff,
  output logic statQ,
  output logic pendQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (forceOff)   statQ <= 1'b0;
      else if (setIn) statQ <= 1'b1;
      else if (clrRd) statQ <= 1'b0;

      if (forceOff)   pendQ <= 1'b0;
      else if (chgIn) pendQ <= 1'b1;
      else if (clrRd) pendQ <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_stat_ctrl.sv
module alarm_stat_ctrl
  import alarm_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output busStrobe_t        strobe
);
  logic hitStat;
  logic hitMask;

  assign hitStat = (addr == STAT_ADDR);
  assign hitMask = (addr == MASK_ADDR);

  always_comb begin
    strobe.statRead  = rdEn & hitStat;
    strobe.maskWrite = wrEn & hitMask;
    strobe.rdStrobe  = rdEn;
    if (hitStat)      strobe.rdSel = SEL_STAT;
    else if (hitMask) strobe.rdSel = SEL_MASK;
    else              strobe.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/alarm_stat_dp.sv
module alarm_stat_dp
  import alarm_stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ALARM_N-1:0] almCond,
  input  logic               txSof,
  input  logic               rxSof,
  input  logic               e3Mode,
  input  logic               masterEn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  logic [ALARM_N-1:0] condQ;
  logic [ALARM_N-1:0] condPrevQ;
  logic [EVENT_N-1:0] evIn;
  logic [STAT_W-1:0]  statVec;
  logic [STAT_W-1:0]  pendVec;
  logic [STAT_W-1:0]  maskQ;
  logic [DATA_W-1:0]  rdNext;

  assign evIn = {rxSof, txSof};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condQ     <= '0;
      condPrevQ <= '0;
    end else begin
      condQ     <= almCond;
      condPrevQ <= condQ;
    end
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    logic setI;
    logic chgI;
    logic offI;
    if (i < ALARM_N) begin : g_alarm
      assign setI = condQ[i];
      assign chgI = condQ[i] ^ condPrevQ[i];
    end else begin : g_event
      assign setI = evIn[i-ALARM_N];
      assign chgI = evIn[i-ALARM_N];
    end
    if (i == IDLE_BIT) begin : g_idle
      assign offI = e3Mode;
    end else begin : g_norm
      assign offI = 1'b0;
    end
    alarm_bit_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .setIn    (setI),
      .chgIn    (chgI),
      .clrRd    (strobe.statRead),
      .forceOff (offI),
      .statQ    (statVec[i]),
      .pendQ    (pendVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 maskQ <= '0;
    else if (strobe.maskWrite) maskQ <= wrData[STAT_W-1:0];
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      SEL_STAT: rdNext[STAT_W-1:0] = statVec;
      SEL_MASK: rdNext[STAT_W-1:0] = maskQ;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdStrobe) rdData <= rdNext;
  end

  assign irq = masterEn & (|(pendVec & maskQ));
endmodule

// File: rtl/alarm_stat_irq.sv
module alarm_stat_irq
  import alarm_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [ALARM_N-1:0] almCond,
  input  logic               txSof,
  input  logic               rxSof,
  input  logic               e3Mode,
  input  logic               masterEn,
  output logic               irq
);
  busStrobe_t strobe;

  alarm_stat_ctrl #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) u_ctrl (
    .addr   (addr),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .strobe (strobe)
  );

  alarm_stat_dp #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .almCond  (almCond),
    .txSof    (txSof),
    .rxSof    (rxSof),
    .e3Mode   (e3Mode),
    .masterEn (masterEn),
    .rdData   (rdData),
    .irq      (irq)
  );
endmodule

// File: rtl/alarm_stat_checker.sv
module alarm_stat_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  addr,
  input logic        rdEn,
  input logic [15:0] rdData,
  input logic [4:0]  almCond,
  input logic        e3Mode,
  input logic        masterEn,
  input logic        irq
);
  logic statRd;
  assign statRd = rdEn && (addr == 8'h12);

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> !irq);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:7] == 9'd0);

  p_alarm_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && $past(almCond[0], 2)) |=> rdData[0]);

  p_e3_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && $past(e3Mode)) |=> !rdData[4]);
endmodule

bind alarm_stat_irq alarm_stat_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .almCond  (almCond),
  .e3Mode   (e3Mode),
  .masterEn (masterEn),
  .irq      (irq)
);

// File: tb/alarm_stat_irq_bench.sv
module alarm_stat_irq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [4:0]  almCond = '0;
  logic        txSof = 1'b0;
  logic        rxSof = 1'b0;
  logic        e3Mode = 1'b0;
  logic        masterEn = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  localparam logic [7:0] A_STAT = 8'h12;
  localparam logic [7:0] A_MASK = 8'h13;

  always #5 clk = ~clk;

  alarm_stat_irq u_alarm_stat_irq (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .almCond(almCond), .txSof(txSof),
    .rxSof(rxSof), .e3Mode(e3Mode), .masterEn(masterEn), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    chk(irq === exp, tag, {15'd0, irq}, {15'd0, exp});
  endtask

  task automatic readReg(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    rdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops the expected word at the falling edge after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() > 0) begin
          logic [15:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(rdData === e, t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdData === 16'd0, "R10 rdData after reset", rdData, 16'd0);
    chkIrq(1'b0, "R10 irq after reset");
    readReg(A_STAT, 16'h0000, "R10 status after reset");
    readReg(A_MASK, 16'h0000, "R10 mask after reset");

    writeReg(A_MASK, 16'h007F);
    readReg(A_MASK, 16'h007F, "R9 mask readback");
    masterEn = 1'b1;

    // R2 / R3 / R5: LOS persists
    @(negedge clk); almCond = 5'b00001;
    settle();
    chkIrq(1'b1, "R3 irq on LOS rise");
    readReg(A_STAT, 16'h0001, "R1 LOS bit0");
    chkIrq(1'b0, "R5 irq released by read");
    readReg(A_STAT, 16'h0001, "R2 LOS held while present");
    @(negedge clk); almCond = 5'b00000;
    settle();
    chkIrq(1'b1, "R3 irq on LOS fall");
    readReg(A_STAT, 16'h0001, "R2 LOS latched after fall");
    readReg(A_STAT, 16'h0000, "R2 LOS cleared by read");
    chkIrq(1'b0, "R5 irq clear after fall read");

    // two alarms at once
    @(negedge clk); almCond = 5'b01010;
    settle();
    readReg(A_STAT, 16'h000A, "R1 LOF and RAI bits");
    @(negedge clk); almCond = 5'b00000;
    settle();
    readReg(A_STAT, 16'h000A, "R2 LOF RAI latched");
    readReg(A_STAT, 16'h0000, "R2 LOF RAI cleared");

    // R6 events
    @(negedge clk); txSof = 1'b1;
    @(negedge clk); txSof = 1'b0;
    chkIrq(1'b1, "R6 irq on txSof");
    readReg(A_STAT, 16'h0020, "R6 TXSOF set");
    readReg(A_STAT, 16'h0000, "R6 TXSOF cleared");
    @(negedge clk); rxSof = 1'b1;
    @(negedge clk); rxSof = 1'b0;
    readReg(A_STAT, 16'h0040, "R6 RXSOF set");
    readReg(A_STAT, 16'h0000, "R6 RXSOF cleared");

    // R4 per-bit mask
    writeReg(A_MASK, 16'h007E);
    @(negedge clk); almCond = 5'b00001;
    settle();
    chkIrq(1'b0, "R4 masked LOS no irq");
    readReg(A_STAT, 16'h0001, "R4 masked LOS still latched");
    @(negedge clk); almCond = 5'b00000;
    settle();
    chkIrq(1'b0, "R4 masked LOS fall no irq");
    readReg(A_STAT, 16'h0001, "R4 LOS latched");
    readReg(A_STAT, 16'h0000, "R4 LOS cleared");
    writeReg(A_MASK, 16'h007F);

    // R4 master enable
    @(negedge clk); masterEn = 1'b0; txSof = 1'b1;
    @(negedge clk); txSof = 1'b0;
    chkIrq(1'b0, "R4 master disabled no irq");
    masterEn = 1'b1;
    @(negedge clk);
    chkIrq(1'b1, "R4 master enabled irq");
    readReg(A_STAT, 16'h0020, "R4 pending TXSOF");
    chkIrq(1'b0, "R5 irq released");

    // R8 collision
    @(negedge clk); addr = A_STAT; rdEn = 1'b1; txSof = 1'b1;
    expQ.push_back(16'h0000); tagQ.push_back("R8 read before event");
    @(negedge clk); rdEn = 1'b0; txSof = 1'b0;
    chkIrq(1'b1, "R8 request kept through read");
    readReg(A_STAT, 16'h0020, "R8 event kept through read");
    chkIrq(1'b0, "R8 released by later read");

    // R7 E3 idle suppression
    @(negedge clk); e3Mode = 1'b1; almCond = 5'b10000;
    settle();
    chkIrq(1'b0, "R7 no irq from idle in E3");
    readReg(A_STAT, 16'h0000, "R7 idle forced 0 in E3");
    @(negedge clk); e3Mode = 1'b0;
    settle();
    readReg(A_STAT, 16'h0010, "R1 IDLE bit4 in T3");
    @(negedge clk); almCond = 5'b00000;
    settle();
    readReg(A_STAT, 16'h0010, "R2 IDLE latched");
    readReg(A_STAT, 16'h0000, "R2 IDLE cleared");

    // R9 writes to status ignored, other addresses
    writeReg(A_STAT, 16'hFFFF);
    readReg(A_STAT, 16'h0000, "R9 status write ignored");
    readReg(A_MASK, 16'h007F, "R9 mask unchanged");
    readReg(8'h20, 16'h0000, "R9 unmapped reads 0");
    chkIrq(1'b0, "R9 no irq from status write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule